// File: doc/BRIEF.md
# Inverted Page Table Address Translator

This block turns a CPU virtual address into a physical address with a content-addressable table. The table has one entry for each physical page, so the index of the entry that matches is the physical page number. One request presents a virtual address, a read/write flag and a privilege flag. Every entry compares its stored virtual page number with the request at the same time. One clock later the block returns the physical address and a hit flag, or it raises an abort so that the access can be restarted.

Because the physical page is the entry position, a single physical page can never be reached through two virtual pages. Software loads entries one at a time through a write port. Each write replaces the entry's virtual page number and its two protection bits, and marks the entry valid. A global invalidate input drops every entry in one cycle. The default geometry is 128 entries of 32 KB pages, which covers 4 MB of physical memory. The physical address is the 7-bit entry index followed by the 15-bit page offset.

Top module: `cam_ipt`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid`, `rsp_hit`, `rsp_abort` and `rsp_pa` are all 0. A lookup made after reset, before any write, returns an abort.
- R2: A request accepted on a clock edge (`req_valid`=1) gives `rsp_valid`=1 after that edge, with exactly one of `rsp_hit` and `rsp_abort` set. A cycle with no request gives `rsp_valid`, `rsp_hit` and `rsp_abort` all 0 after the edge.
- R3: On a hit, `rsp_pa` = {matching entry index, `req_va[14:0]`}.
- R4: When no valid entry holds the virtual page number `req_va[25:15]`, the response is an abort with `rsp_pa` = 0.
- R5: A write (`wr_en`) to entry `wr_idx` fully replaces that entry's virtual page number and protection bits and marks it valid. The page number it held before no longer matches.
- R6: When two or more valid entries hold the requested virtual page number, the response is an abort with `rsp_pa` = 0. The block does not pick one of them by priority.
- R7: The protection field sets the access rights of user mode (`req_super`=0): 2'b00 allows read and write, 2'b01 allows read only, and 2'b10 or 2'b11 allow no access. A user access that is not allowed aborts. A supervisor access (`req_super`=1) is never refused by the protection field.
- R8: `inv_all` makes every entry invalid at the clock edge, so later lookups abort until the entries are written again. A write in the same cycle as `inv_all` still leaves its own entry valid with the new contents.
- R9: A lookup in the same cycle as a write sees the table as it was before that write.
- R10: The page offset bits `req_va[14:0]` have no effect on whether a lookup hits or aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 26 | Virtual address of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| wr_en | input | 1 | Load one table entry |
| wr_idx | input | 7 | Index (physical page) of the entry to load |
| wr_vpn | input | 11 | Virtual page number to store |
| wr_prot | input | 2 | Protection bits to store |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_abort | output | 1 | Translation failed: miss, duplicate or protection |
| rsp_pa | output | 22 | Physical address; 0 on abort |

## Verification
The bench fills all 128 entries with distinct page numbers and all four protection codes. It then sweeps every entry in both privilege modes with reads and writes. This finds a wrong index encoding, since the physical page would come out wrong, and a protection decode that mixes up read-only and no-access. It creates a duplicate mapping on purpose: a design that resolved duplicates by priority would return a hit instead of an abort. It also overwrites an entry: a design that kept the old page number would still hit on the stale address. Further cases cover a write in the same cycle as a lookup, where early forwarding would show the new contents, and an invalidate in the same cycle as a write, where the wrong priority would lose the new entry. A last case changes only the offset bits, which must not change the result.

// File: rtl/cam_ipt_pkg.sv
package cam_ipt_pkg;

    // User-mode access rights held in each entry
    typedef enum logic [1:0] {
        PROT_USER_RW  = 2'b00,
        PROT_USER_RO  = 2'b01,
        PROT_NONE_LO  = 2'b10,
        PROT_NONE_HI  = 2'b11
    } prot_e;

    function automatic logic access_ok(input logic [1:0] prot,
                                       input logic       is_write,
                                       input logic       is_super);
        logic ok;
        ok = 1'b0;
        if (is_super) begin
            ok = 1'b1;
        end else begin
            unique case (prot_e'(prot))
                PROT_USER_RW: ok = 1'b1;
                PROT_USER_RO: ok = !is_write;
                default:      ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/cam_ipt_entry.sv
module cam_ipt_entry #(
    parameter int VPN_W = 11,
    parameter int IDX_W = 7,
    parameter int INDEX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [1:0]       wr_prot,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             match,
    output logic [1:0]       prot
);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [1:0]       prot;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (inv_all) begin
            slot_d.valid = 1'b0;
        end
        if (wr_en && (wr_idx == IDX_W'(INDEX))) begin
            slot_d.valid = 1'b1;
            slot_d.vpn   = wr_vpn;
            slot_d.prot  = wr_prot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign match = slot_q.valid && (slot_q.vpn == lk_vpn);
    assign prot  = slot_q.prot;

endmodule

// File: rtl/cam_ipt_resolve.sv
module cam_ipt_resolve #(
    parameter int ENTRIES = 128,
    parameter int IDX_W   = 7
) (
    input  logic [ENTRIES-1:0]      match,
    input  logic [ENTRIES-1:0][1:0] prot,
    output logic                    any,
    output logic                    multi,
    output logic [IDX_W-1:0]        idx,
    output logic [1:0]              sel_prot
);

    always_comb begin
        any      = 1'b0;
        multi    = 1'b0;
        idx      = '0;
        sel_prot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                if (any) begin
                    multi = 1'b1;
                end
                any      = 1'b1;
                idx      = idx | IDX_W'(i);
                sel_prot = sel_prot | prot[i];
            end
        end
    end

endmodule

// File: rtl/cam_ipt.sv
module cam_ipt #(
    parameter int VA_W     = 26,
    parameter int OFFSET_W = 15,
    parameter int ENTRIES  = 128,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int VPN_W   = VA_W - OFFSET_W,
    localparam int PA_W    = IDX_W + OFFSET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             req_super,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [1:0]       wr_prot,
    input  logic             inv_all,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_abort,
    output logic [PA_W-1:0]  rsp_pa
);
    import cam_ipt_pkg::*;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            abort;
        logic [PA_W-1:0] pa;
    } rsp_t;

    logic [VPN_W-1:0]          lk_vpn;
    logic [OFFSET_W-1:0]       lk_off;
    logic [ENTRIES-1:0]        entry_match;
    logic [ENTRIES-1:0][1:0]   entry_prot;
    logic                      any_match;
    logic                      multi_match;
    logic [IDX_W-1:0]          match_idx;
    logic [1:0]                match_prot;
    rsp_t                      rsp_d, rsp_q;

    assign lk_vpn = req_va[VA_W-1:OFFSET_W];
    assign lk_off = req_va[OFFSET_W-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        cam_ipt_entry #(
            .VPN_W (VPN_W),
            .IDX_W (IDX_W),
            .INDEX (g)
        ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .inv_all (inv_all),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_vpn  (wr_vpn),
            .wr_prot (wr_prot),
            .lk_vpn  (lk_vpn),
            .match   (entry_match[g]),
            .prot    (entry_prot[g])
        );
    end

    cam_ipt_resolve #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_resolve (
        .match    (entry_match),
        .prot     (entry_prot),
        .any      (any_match),
        .multi    (multi_match),
        .idx      (match_idx),
        .sel_prot (match_prot)
    );

    always_comb begin
        logic ok;
        rsp_d = '0;
        ok    = any_match && !multi_match
                && access_ok(match_prot, req_write, req_super);
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.hit   = ok;
            rsp_d.abort = !ok;
            rsp_d.pa    = ok ? {match_idx, lk_off} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_abort = rsp_q.abort;
    assign rsp_pa    = rsp_q.pa;

endmodule

// File: rtl/cam_ipt_chk.sv
module cam_ipt_chk #(
    parameter int VA_W     = 26,
    parameter int OFFSET_W = 15,
    parameter int ENTRIES  = 128,
    parameter int PA_W     = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VA_W-1:0]    req_va,
    input logic [ENTRIES-1:0] entry_match,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_abort,
    input logic [PA_W-1:0]    rsp_pa
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && (rsp_hit != rsp_abort)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_abort));

    // R3
    offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || (rsp_pa[OFFSET_W-1:0] == $past(req_va[OFFSET_W-1:0]))));

    // R6
    hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || $onehot($past(entry_match))));

    // R4
    abort_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> (rsp_pa == '0));

endmodule

bind cam_ipt cam_ipt_chk #(
    .VA_W     (VA_W),
    .OFFSET_W (OFFSET_W),
    .ENTRIES  (ENTRIES),
    .PA_W     (PA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_va      (req_va),
    .entry_match (entry_match),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_abort   (rsp_abort),
    .rsp_pa      (rsp_pa)
);

// File: tb/cam_ipt_tb.sv
module cam_ipt_tb;
    localparam int VA_W = 26, OFF = 15, N = 128, IW = 7, VW = 11, PW = 22;
    localparam int RW = 3 + PW;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_super = 0;
    logic [VA_W-1:0] req_va = '0;
    logic wr_en = 0, inv_all = 0;
    logic [IW-1:0] wr_idx = '0;
    logic [VW-1:0] wr_vpn = '0;
    logic [1:0] wr_prot = '0;
    logic rsp_valid, rsp_hit, rsp_abort;
    logic [PW-1:0] rsp_pa;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [VW-1:0] m_vpn [N];
    logic [1:0]    m_prot[N];
    logic          m_val [N];

    always #2.5 clk = ~clk;

    cam_ipt u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_super(req_super), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_prot(wr_prot), .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_abort(rsp_abort),
        .rsp_pa(rsp_pa)
    );

    task automatic chk(input string tag, input logic [RW-1:0] exp);
        logic [RW-1:0] act;
        act = {rsp_valid, rsp_hit, rsp_abort, rsp_pa};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference result from the bench's own table copy
    function automatic logic [RW-1:0] model(input logic [VA_W-1:0] va,
                                            input logic w, input logic s);
        int cnt = 0, idx = 0;
        logic ok;
        for (int i = 0; i < N; i++) begin
            if (m_val[i] && m_vpn[i] == va[VA_W-1:OFF]) begin
                cnt++;
                idx = i;
            end
        end
        ok = (cnt == 1) && (s || m_prot[idx] == 2'b00 ||
                            (m_prot[idx] == 2'b01 && !w));
        return ok ? {3'b110, IW'(idx), va[OFF-1:0]} : {3'b101, PW'(0)};
    endfunction

    task automatic lookup(input logic [VA_W-1:0] va, input logic w,
                          input logic s, input string tag);
        logic [RW-1:0] exp;
        exp = model(va, w, s);
        req_valid = 1; req_va = va; req_write = w; req_super = s;
        @(negedge clk);
        req_valid = 0;
        chk(tag, exp);
    endtask

    task automatic load(input int idx, input logic [VW-1:0] vpn,
                        input logic [1:0] p);
        wr_en = 1; wr_idx = IW'(idx); wr_vpn = vpn; wr_prot = p;
        @(negedge clk);
        wr_en = 0;
        m_vpn[idx] = vpn; m_prot[idx] = p; m_val[idx] = 1;
    endtask

    function automatic logic [VW-1:0] vpn_of(input int i);
        return VW'(i * 13 + 5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] exp;
        for (int i = 0; i < N; i++) begin
            m_val[i] = 0; m_vpn[i] = '0; m_prot[i] = '0;
        end
        @(negedge clk);
        // R1: outputs cleared in reset
        chk("R1 reset outputs", '0);
        rst_n = 1;
        @(negedge clk);
        lookup({vpn_of(0), 15'h0123}, 0, 1, "R1 empty table aborts");
        // R2: idle cycle gives no response
        @(negedge clk);
        chk("R2 idle quiet", '0);

        // R5: fill every entry, all protection codes
        for (int i = 0; i < N; i++) load(i, vpn_of(i), 2'(i % 4));

        // R3 R7: sweep every entry, both modes, read and write
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 4; m++) begin
                lookup({vpn_of(i), 15'(i * 251 + m)}, m[0], m[1],
                       "R3/R7 sweep");
            end
        end

        // R4: page number held by no entry
        lookup({11'h7FF, 15'h4000}, 0, 1, "R4 miss");

        // R10: only offset differs, result stays the same
        lookup({vpn_of(8), 15'h0000}, 0, 0, "R10 offset low");
        lookup({vpn_of(8), 15'h7FFF}, 0, 0, "R10 offset high");
        lookup({vpn_of(9), 15'h7FFF}, 1, 0, "R10 offset ro write");

        // R6: duplicate mapping aborts even for supervisor
        load(3, vpn_of(7), 2'b00);
        lookup({vpn_of(7), 15'h0042}, 0, 1, "R6 duplicate aborts");
        // R5: old page number of entry 3 no longer matches
        lookup({vpn_of(3), 15'h0042}, 0, 1, "R5 old vpn gone");
        load(3, vpn_of(3), 2'b00);
        lookup({vpn_of(7), 15'h0042}, 0, 1, "R5 duplicate removed");
        lookup({vpn_of(3), 15'h0001}, 1, 0, "R5 new prot applied");

        // R9: lookup during a write sees the prior contents
        exp = model({vpn_of(20), 15'h0010}, 0, 1);
        wr_en = 1; wr_idx = 7'd20; wr_vpn = 11'h7FE; wr_prot = 2'b00;
        req_valid = 1; req_va = {vpn_of(20), 15'h0010}; req_write = 0; req_super = 1;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        m_vpn[20] = 11'h7FE; m_prot[20] = 2'b00;
        chk("R9 write same cycle old view", exp);
        lookup({11'h7FE, 15'h0010}, 1, 0, "R9 new contents after");

        // R8: invalidate with a simultaneous write to entry 50
        inv_all = 1;
        wr_en = 1; wr_idx = 7'd50; wr_vpn = 11'h7FD; wr_prot = 2'b01;
        @(negedge clk);
        inv_all = 0; wr_en = 0;
        for (int i = 0; i < N; i++) m_val[i] = 0;
        m_val[50] = 1; m_vpn[50] = 11'h7FD; m_prot[50] = 2'b01;
        lookup({vpn_of(0), 15'h0}, 0, 1, "R8 entry 0 invalid");
        lookup({vpn_of(127), 15'h0}, 0, 1, "R8 entry 127 invalid");
        lookup({11'h7FD, 15'h0555}, 0, 0, "R8 same-cycle write kept");
        lookup({11'h7FD, 15'h0555}, 1, 0, "R7 read-only write aborts");
        load(0, vpn_of(0), 2'b10);
        lookup({vpn_of(0), 15'h0}, 0, 0, "R7 no user access");
        lookup({vpn_of(0), 15'h0}, 1, 1, "R7 supervisor allowed");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule